// File: doc/BRIEF.md
# Time-Window Hit Packetizer

The packetizer sits behind several hit lanes and next to a free-running system timestamp. It cuts time into fixed windows of `WIN_W` ticks. While a window is open, each lane stores the hits whose timestamps fall inside it. A window is closed only once its upper edge lies at least `SAFE_DELAY` ticks behind the system time. With the default settings, the window covering 400 up to (but not including) 500 closes when the system time reaches 1000.

At the close, every lane frames its packet for that window in the same cycle. A packet is a header that carries the window start, then the lane's hits in arrival order, then an end-of-packet word. A lane that saw no hits still emits a header followed at once by end-of-packet. A merger copies the packets to a single output stream in increasing lane order, one whole packet after another. The window is finished only when the end-of-packet word of the last lane has left. The window start then moves up by one width and collection resumes.

Hits older than the open window are taken and thrown away, and a saturating counter records them. Hits newer than the open window are held back with a low ready until the window reaches them.

Top module: `twp_packetizer`

## Requirements
- R1: After reset, `out_valid` is 0, `drop_count` is 0, and the first window starts at `WIN_START`.
- R2: A window whose start is S closes in the cycle in which `sys_time` first reaches S + `WIN_W` + `SAFE_DELAY`. The first output word is valid in the next cycle, and no word is valid before that.
- R3: Output word kinds are encoded in `out_kind` as 2'b01 header, 2'b10 hit and 2'b11 end-of-packet. Header and end-of-packet words carry the window start in `out_ts` and zero in `out_data`. `out_lane` gives the source lane of every word.
- R4: A hit with window start S <= ts < S + `WIN_W` is accepted. It appears in its lane's packet as a hit word with its own `ts` and data, in the order the lane accepted it. Both window edges count as shown.
- R5: A lane with no accepted hits for a window still emits a header immediately followed by an end-of-packet word.
- R6: Packets leave in increasing lane order. Each lane's end-of-packet is followed directly, in the next valid word, by the header of the next lane. The window's output ends with the last lane's end-of-packet.
- R7: After the last end-of-packet is accepted, the window start advances by `WIN_W`. The next window closes at its own threshold.
- R8: A hit with ts < window start is accepted with `hit_ready` high and does not appear in the output. It adds one to `drop_count`. Drops on several lanes in one cycle add one each, and `drop_count` saturates at its maximum value.
- R9: A hit with ts >= window start + `WIN_W` sees `hit_ready` low until a later window covers it.
- R10: From the closing cycle until the window's output is complete, `hit_ready` is low on every lane.
- R11: While `out_valid` is high and `out_ready` is low, every output field keeps its value into the next cycle.
- R12: A lane that holds `LANE_DEPTH` hits of the open window drives `hit_ready` low for further in-window hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | TS_W | Free-running system timestamp |
| hit_valid | input | NUM_LANES | Per-lane hit offered |
| hit_ts | input | NUM_LANES*TS_W | Per-lane hit timestamp, lane 0 in the low bits |
| hit_data | input | NUM_LANES*DATA_W | Per-lane hit payload, lane 0 in the low bits |
| hit_ready | output | NUM_LANES | Per-lane hit taken (stored or dropped) |
| out_ready | input | 1 | Downstream accepts the output word |
| out_valid | output | 1 | Output word present |
| out_kind | output | 2 | Word kind: 01 header, 10 hit, 11 end-of-packet |
| out_lane | output | $clog2(NUM_LANES) | Source lane of the word |
| out_ts | output | TS_W | Hit timestamp, or window start for header and end-of-packet |
| out_data | output | DATA_W | Hit payload, zero for header and end-of-packet |
| drop_count | output | ERR_W | Saturating count of hits older than the open window |

## Verification
Two pairs of functions can land in the same cycle: the window close with a hit that is waiting at a lane, and drops on several lanes at once.

For the first pair, a hit beyond the open window is kept waiting across the close. The bench checks that `hit_ready` stays low in the closing cycle and through the whole merge. It then checks that the hit is taken into the following window. A full lane's surplus hit is held across a close in the same way, so that it ages out. The bench then checks that it is counted as a drop and never emitted.

For the second pair, stale hits are presented on two lanes, and later on all four, in the same cycles. The counter must grow by the number of lanes per cycle and must stop at its maximum. A scoreboard compares every output word with the expected lane-ordered packets while `out_ready` toggles.

// File: rtl/twp_pkg.sv
package twp_pkg;

  // Kind of a word on the merged output stream.
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_HDR  = 2'b01,
    KIND_HIT  = 2'b10,
    KIND_EOP  = 2'b11
  } word_kind_e;

  // Per-lane framing state.
  typedef enum logic [1:0] {
    LS_IDLE,
    LS_HDR,
    LS_BODY,
    LS_EOP
  } lane_state_e;

endpackage

// File: rtl/twp_window.sv
// Window bookkeeping: holds the open window start and decides when it
// lies far enough behind system time to be packed.
module twp_window #(
  parameter int TS_W       = 16,
  parameter int WIN_W      = 100,
  parameter int SAFE_DELAY = 500,
  parameter int WIN_START  = 400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] sys_time,
  input  logic            merge_done,
  output logic [TS_W-1:0] win_start,
  output logic [TS_W-1:0] win_end,
  output logic            collecting,
  output logic            close_now
);

  localparam logic [TS_W-1:0] STEP  = TS_W'(WIN_W);
  localparam logic [TS_W-1:0] DELAY = TS_W'(SAFE_DELAY);
  localparam logic [TS_W-1:0] FIRST = TS_W'(WIN_START);

  logic [TS_W-1:0] start_n;
  logic            coll_n;
  logic            adv_en;
  logic [TS_W-1:0] close_at;

  assign win_end   = win_start + STEP;
  assign close_at  = win_end + DELAY;
  assign close_now = collecting && (sys_time >= close_at);

  always_comb begin
    adv_en  = !collecting && merge_done;
    start_n = win_start + STEP;
    coll_n  = collecting;
    if (close_now) begin
      coll_n = 1'b0;
    end else if (adv_en) begin
      coll_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_start  <= FIRST;
      collecting <= 1'b1;
    end else begin
      if (adv_en) begin
        win_start <= start_n;
      end
      collecting <= coll_n;
    end
  end

endmodule

// File: rtl/twp_lane.sv
// One hit lane: classifies incoming hits against the open window, buffers
// in-window hits, and frames them into a header / hits / end-of-packet
// packet once the window closes.
module twp_lane
  import twp_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8   // power of two, at least 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [TS_W-1:0]   hit_ts,
  input  logic [DATA_W-1:0] hit_data,
  output logic              hit_ready,
  output logic              drop,
  input  logic [TS_W-1:0]   win_start,
  input  logic [TS_W-1:0]   win_end,
  input  logic              collecting,
  input  logic              close_now,
  input  logic              pk_pop,
  output logic              pk_valid,
  output logic [1:0]        pk_kind,
  output logic [TS_W-1:0]   pk_ts,
  output logic [DATA_W-1:0] pk_data
);

  localparam int              AW       = $clog2(DEPTH);
  localparam logic [AW:0]     FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0]     ONE_LVL  = (AW+1)'(1);

  logic [TS_W-1:0]   mem_ts   [DEPTH];
  logic [DATA_W-1:0] mem_data [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       level, level_n;
  lane_state_e       state, state_n;

  logic is_old, is_new, in_win, open_win, full, empty;
  logic push, pop_fifo;

  always_comb begin
    is_old   = hit_ts < win_start;
    is_new   = hit_ts >= win_end;
    in_win   = !is_old && !is_new;
    open_win = collecting && !close_now && (state == LS_IDLE);
    full     = (level == FULL_LVL);
    empty    = (level == '0);
    push     = hit_valid && open_win && in_win && !full;
    pop_fifo = pk_pop && (state == LS_BODY);
  end

  assign hit_ready = open_win && (is_old || (in_win && !full));
  assign drop      = hit_valid && open_win && is_old;

  // Framing next state.
  always_comb begin
    state_n = state;
    unique case (state)
      LS_IDLE: if (close_now) state_n = LS_HDR;
      LS_HDR:  if (pk_pop)    state_n = empty ? LS_EOP : LS_BODY;
      LS_BODY: if (pk_pop && (level == ONE_LVL)) state_n = LS_EOP;
      LS_EOP:  if (pk_pop)    state_n = LS_IDLE;
      default:                state_n = LS_IDLE;
    endcase
  end

  always_comb begin
    level_n = level;
    if (push) begin
      level_n = level + ONE_LVL;
    end else if (pop_fifo) begin
      level_n = level - ONE_LVL;
    end
  end

  // Packet word presented to the merger.
  always_comb begin
    pk_valid = (state != LS_IDLE);
    pk_kind  = KIND_NONE;
    pk_ts    = win_start;
    pk_data  = '0;
    unique case (state)
      LS_HDR:  pk_kind = KIND_HDR;
      LS_BODY: begin
        pk_kind = KIND_HIT;
        pk_ts   = mem_ts[rd_ptr];
        pk_data = mem_data[rd_ptr];
      end
      LS_EOP:  pk_kind = KIND_EOP;
      default: pk_kind = KIND_NONE;
    endcase
  end

  // Hit storage, no reset on the array.
  always_ff @(posedge clk) begin
    if (push) begin
      mem_ts[wr_ptr]   <= hit_ts;
      mem_data[wr_ptr] <= hit_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      state  <= LS_IDLE;
    end else begin
      if (push) begin
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop_fifo) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
      level <= level_n;
      state <= state_n;
    end
  end

endmodule

// File: rtl/twp_merge.sv
// Lane-ordered merger: forwards the packet of the current lane word by
// word, steps to the next lane on end-of-packet, and signals completion
// after the last lane's end-of-packet.
module twp_merge
  import twp_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int TS_W      = 16,
  parameter int DATA_W    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_LANES-1:0]               pk_valid,
  input  logic [NUM_LANES-1:0][1:0]          pk_kind,
  input  logic [NUM_LANES-1:0][TS_W-1:0]     pk_ts,
  input  logic [NUM_LANES-1:0][DATA_W-1:0]   pk_data,
  output logic [NUM_LANES-1:0]               pk_pop,
  input  logic                               out_ready,
  output logic                               out_valid,
  output logic [1:0]                         out_kind,
  output logic [$clog2(NUM_LANES)-1:0]       out_lane,
  output logic [TS_W-1:0]                    out_ts,
  output logic [DATA_W-1:0]                  out_data,
  output logic                               merge_done
);

  localparam int            LW   = $clog2(NUM_LANES);
  localparam logic [LW-1:0] LAST = LW'(NUM_LANES - 1);

  logic [LW-1:0] cur, cur_n;
  logic          fire, eop_fire, cur_en;

  always_comb begin
    out_valid = pk_valid[cur];
    out_kind  = pk_kind[cur];
    out_ts    = pk_ts[cur];
    out_data  = pk_data[cur];
    out_lane  = cur;
    fire      = out_valid && out_ready;
    eop_fire  = fire && (out_kind == KIND_EOP);
    merge_done = eop_fire && (cur == LAST);
    cur_en    = eop_fire;
    cur_n     = (cur == LAST) ? '0 : cur + 1'b1;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pop
    assign pk_pop[g] = fire && (cur == LW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (cur_en) begin
      cur <= cur_n;
    end
  end

endmodule

// File: rtl/twp_drop_ctr.sv
// Saturating counter of stale hits, adding every lane's drop in a cycle.
module twp_drop_ctr #(
  parameter int NUM_LANES = 4,
  parameter int ERR_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] drop,
  output logic [ERR_W-1:0]     count
);

  localparam int               SW  = ERR_W + $clog2(NUM_LANES + 1);
  localparam logic [ERR_W-1:0] MAX = '1;

  logic [SW-1:0]    sum;
  logic [ERR_W-1:0] count_n;
  logic             cnt_en;

  always_comb begin
    sum = SW'(count);
    for (int i = 0; i < NUM_LANES; i++) begin
      sum = sum + SW'(drop[i]);
    end
    count_n = (sum > SW'(MAX)) ? MAX : sum[ERR_W-1:0];
    cnt_en  = |drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_en) begin
      count <= count_n;
    end
  end

endmodule

// File: rtl/twp_packetizer.sv
// Top: time-window hit packetizer.
module twp_packetizer
  import twp_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int TS_W       = 16,
  parameter int DATA_W     = 16,
  parameter int WIN_W      = 100,
  parameter int SAFE_DELAY = 500,
  parameter int WIN_START  = 400,
  parameter int LANE_DEPTH = 8,
  parameter int ERR_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TS_W-1:0]               sys_time,
  input  logic [NUM_LANES-1:0]          hit_valid,
  input  logic [NUM_LANES*TS_W-1:0]     hit_ts,
  input  logic [NUM_LANES*DATA_W-1:0]   hit_data,
  output logic [NUM_LANES-1:0]          hit_ready,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [1:0]                    out_kind,
  output logic [$clog2(NUM_LANES)-1:0]  out_lane,
  output logic [TS_W-1:0]               out_ts,
  output logic [DATA_W-1:0]             out_data,
  output logic [ERR_W-1:0]              drop_count
);

  logic [TS_W-1:0] win_start, win_end;
  logic            collecting, close_now, merge_done;

  logic [NUM_LANES-1:0]             lane_drop;
  logic [NUM_LANES-1:0]             pk_valid, pk_pop;
  logic [NUM_LANES-1:0][1:0]        pk_kind;
  logic [NUM_LANES-1:0][TS_W-1:0]   pk_ts;
  logic [NUM_LANES-1:0][DATA_W-1:0] pk_data;

  twp_window #(
    .TS_W(TS_W), .WIN_W(WIN_W), .SAFE_DELAY(SAFE_DELAY), .WIN_START(WIN_START)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .merge_done(merge_done),
    .win_start(win_start), .win_end(win_end),
    .collecting(collecting), .close_now(close_now)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    twp_lane #(.TS_W(TS_W), .DATA_W(DATA_W), .DEPTH(LANE_DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .hit_valid(hit_valid[g]),
      .hit_ts(hit_ts[g*TS_W +: TS_W]),
      .hit_data(hit_data[g*DATA_W +: DATA_W]),
      .hit_ready(hit_ready[g]),
      .drop(lane_drop[g]),
      .win_start(win_start), .win_end(win_end),
      .collecting(collecting), .close_now(close_now),
      .pk_pop(pk_pop[g]),
      .pk_valid(pk_valid[g]), .pk_kind(pk_kind[g]),
      .pk_ts(pk_ts[g]), .pk_data(pk_data[g])
    );
  end

  twp_merge #(.NUM_LANES(NUM_LANES), .TS_W(TS_W), .DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .pk_valid(pk_valid), .pk_kind(pk_kind), .pk_ts(pk_ts), .pk_data(pk_data),
    .pk_pop(pk_pop), .out_ready(out_ready),
    .out_valid(out_valid), .out_kind(out_kind), .out_lane(out_lane),
    .out_ts(out_ts), .out_data(out_data), .merge_done(merge_done)
  );

  twp_drop_ctr #(.NUM_LANES(NUM_LANES), .ERR_W(ERR_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .drop(lane_drop), .count(drop_count)
  );

endmodule

// File: rtl/twp_checker.sv
// Property checker bound to the packetizer top.
module twp_checker #(
  parameter int NUM_LANES  = 4,
  parameter int TS_W       = 16,
  parameter int DATA_W     = 16,
  parameter int WIN_W      = 100,
  parameter int SAFE_DELAY = 500,
  parameter int ERR_W      = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [TS_W-1:0]              sys_time,
  input logic [NUM_LANES-1:0]         hit_ready,
  input logic                         out_ready,
  input logic                         out_valid,
  input logic [1:0]                   out_kind,
  input logic [$clog2(NUM_LANES)-1:0] out_lane,
  input logic [TS_W-1:0]              out_ts,
  input logic [DATA_W-1:0]            out_data,
  input logic [ERR_W-1:0]             drop_count,
  input logic [TS_W-1:0]              win_start
);

  localparam int            LW        = $clog2(NUM_LANES);
  localparam logic [LW-1:0] LAST      = LW'(NUM_LANES - 1);
  localparam logic [TS_W-1:0] GAP     = TS_W'(WIN_W + SAFE_DELAY);

  logic [TS_W-1:0] threshold;
  assign threshold = win_start + GAP;

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sys_time >= threshold)); // R2

  AST_FRAME_TS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'b10) |-> (out_ts == win_start && out_data == '0)); // R3

  AST_LANE_SUCCESSION: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'b11 && out_lane != LAST)
    |=> (out_valid && out_kind == 2'b01 && out_lane == LW'($past(out_lane) + 1'b1))); // R6

  AST_DROP_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count >= $past(drop_count))); // R8

  AST_NO_INTAKE_WHILE_PACKING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (hit_ready == '0)); // R10

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_lane)
                                   && $stable(out_ts) && $stable(out_data))); // R11

endmodule

bind twp_packetizer twp_checker #(
  .NUM_LANES(NUM_LANES), .TS_W(TS_W), .DATA_W(DATA_W),
  .WIN_W(WIN_W), .SAFE_DELAY(SAFE_DELAY), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .hit_ready(hit_ready),
  .out_ready(out_ready), .out_valid(out_valid), .out_kind(out_kind),
  .out_lane(out_lane), .out_ts(out_ts), .out_data(out_data),
  .drop_count(drop_count), .win_start(win_start)
);

// File: tb/twp_packetizer_tb.sv
module twp_packetizer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int TW = 16;
  localparam int DW = 16;

  typedef struct packed {
    logic [1:0]    kind;
    logic [1:0]    lane;
    logic [TW-1:0] ts;
    logic [DW-1:0] data;
  } item_t;

  logic            clk;
  logic            rst_n;
  logic [TW-1:0]   sys_time;
  logic [L-1:0]    hit_valid;
  logic [L*TW-1:0] hit_ts;
  logic [L*DW-1:0] hit_data;
  logic [L-1:0]    hit_ready;
  logic            out_ready;
  logic            out_valid;
  logic [1:0]      out_kind;
  logic [1:0]      out_lane;
  logic [TW-1:0]   out_ts;
  logic [DW-1:0]   out_data;
  logic [7:0]      drop_count;

  int n_tests = 0;
  int n_fail  = 0;
  item_t exp_q[$];
  item_t pend_q[$];
  logic held3_done = 1'b0;
  logic extra0_done = 1'b0;

  twp_packetizer u_dut (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
    .hit_valid(hit_valid), .hit_ts(hit_ts), .hit_data(hit_data),
    .hit_ready(hit_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_kind(out_kind), .out_lane(out_lane), .out_ts(out_ts),
    .out_data(out_data), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Free-running system time, driven by the bench.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_time <= '0;
    else        sys_time <= sys_time + 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Record a hit expected in the next window pushed to the scoreboard.
  task automatic note_hit(input int lane, input int ts, input int data);
    pend_q.push_back({2'b10, 2'(lane), TW'(ts), DW'(data)});
  endtask

  // Expected packets for one window: lanes in order, header, hits, end (R5, R6).
  task automatic push_window(input int start);
    for (int l = 0; l < L; l++) begin
      exp_q.push_back({2'b01, 2'(l), TW'(start), DW'(0)});
      foreach (pend_q[i]) if (pend_q[i].lane == 2'(l)) exp_q.push_back(pend_q[i]);
      exp_q.push_back({2'b11, 2'(l), TW'(start), DW'(0)});
    end
    pend_q.delete();
  endtask

  task automatic send_hit(input int lane, input int ts, input int data);
    @(posedge clk); #1;
    hit_valid[lane] = 1'b1;
    hit_ts[lane*TW +: TW] = TW'(ts);
    hit_data[lane*DW +: DW] = DW'(data);
    do @(negedge clk); while (!hit_ready[lane]);
    @(posedge clk); #1;
    hit_valid[lane] = 1'b0;
  endtask

  task automatic wait_time(input int t);
    while (sys_time != TW'(t)) @(negedge clk);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      item_t got;
      got = {out_kind, out_lane, out_ts, out_data};
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 R4 R5 R6 stream: actual %h expected none", got);
      end else begin
        item_t want;
        want = exp_q.pop_front();
        if (got !== want) begin
          n_fail++;
          $display("FAIL R3 R4 R5 R6 stream: actual %h expected %h", got, want);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hit_valid = '0;
    hit_ts = '0;
    hit_data = '0;
    out_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    chk("R1 drop_count after reset", 32'(drop_count), 0);

    // Window 400..499: edges and an empty lane 1.
    send_hit(0, 410, 16'hA1); note_hit(0, 410, 16'hA1);
    send_hit(0, 450, 16'hA2); note_hit(0, 450, 16'hA2);
    send_hit(2, 499, 16'hC1); note_hit(2, 499, 16'hC1); // R4 upper edge
    send_hit(3, 400, 16'hD1); note_hit(3, 400, 16'hD1); // R4 lower edge
    send_hit(1, 399, 16'hEE);                           // stale
    chk("R8 single stale drop", 32'(drop_count), 1);

    // Stale hits on two lanes in the same cycle.
    @(posedge clk); #1;
    hit_valid[0] = 1'b1; hit_ts[0*TW +: TW] = 16'd100;
    hit_valid[2] = 1'b1; hit_ts[2*TW +: TW] = 16'd100;
    @(negedge clk);
    chk("R8 stale ready lanes 0 and 2", 32'({hit_ready[2], hit_ready[0]}), 3);
    @(posedge clk); #1;
    hit_valid[0] = 1'b0; hit_valid[2] = 1'b0;
    @(negedge clk);
    chk("R8 simultaneous drops", 32'(drop_count), 3);

    push_window(400);

    // Future hit on lane 3 waits for the next window.
    @(posedge clk); #1;
    hit_valid[3] = 1'b1; hit_ts[3*TW +: TW] = 16'd500; hit_data[3*DW +: DW] = 16'hD2;
    note_hit(3, 500, 16'hD2);
    @(negedge clk);
    chk("R9 future hit held", 32'(hit_ready[3]), 0);
    repeat (2) @(negedge clk);
    chk("R9 future hit still held", 32'(hit_ready[3]), 0);
    fork
      begin
        do @(negedge clk); while (!hit_ready[3]);
        @(posedge clk); #1;
        hit_valid[3] = 1'b0;
        held3_done = 1'b1;
      end
    join_none

    out_ready = 1'b0;
    wait_time(999);
    chk("R2 no output before threshold", 32'(out_valid), 0);
    @(negedge clk);
    chk("R2 no output in closing cycle", 32'(out_valid), 0);
    chk("R10 intake closed in closing cycle", 32'(hit_ready), 0);
    @(negedge clk);
    chk("R2 output valid after close", 32'(out_valid), 1);
    chk("R3 first word is header", 32'(out_kind), 1);
    chk("R3 header window start", 32'(out_ts), 400);
    chk("R3 header from lane 0", 32'(out_lane), 0);
    @(negedge clk);
    chk("R11 word held kind", 32'(out_kind), 1);
    chk("R11 word held ts", 32'(out_ts), 400);
    chk("R10 intake closed during merge", 32'(hit_ready), 0);
    repeat (12) begin
      @(posedge clk); #1 out_ready = ~out_ready;
    end
    out_ready = 1'b1;

    wait (held3_done);
    @(negedge clk);
    chk("R9 held hit taken by next window", 32'(held3_done), 1);

    // Window 500..599: fill lane 0.
    for (int i = 0; i < 8; i++) begin
      send_hit(0, 510 + i, 16'h100 + i);
      note_hit(0, 510 + i, 16'h100 + i);
    end
    @(posedge clk); #1;
    hit_valid[0] = 1'b1; hit_ts[0*TW +: TW] = 16'd520; hit_data[0*DW +: DW] = 16'hBAD;
    @(negedge clk);
    chk("R12 full lane refuses hit", 32'(hit_ready[0]), 0);
    fork
      begin
        do @(negedge clk); while (!hit_ready[0]);
        @(posedge clk); #1;
        hit_valid[0] = 1'b0;
        extra0_done = 1'b1;
      end
    join_none
    push_window(500);
    push_window(600);   // all lanes empty (R5)

    wait_time(1101);
    chk("R7 second window header ts", 32'(out_ts), 500);
    chk("R7 second window header kind", 32'(out_kind), 1);

    wait (extra0_done);
    @(negedge clk);
    chk("R8 aged-out hit dropped", 32'(drop_count), 4);

    push_window(700);
    wait_time(1220);

    // All four lanes stale at once, then saturation.
    @(posedge clk); #1;
    for (int l = 0; l < L; l++) begin
      hit_valid[l] = 1'b1; hit_ts[l*TW +: TW] = 16'd5;
    end
    @(negedge clk);
    chk("R8 all lanes take stale hits", 32'(hit_ready), 15);
    @(posedge clk);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R8 four drops per cycle", 32'(drop_count), 12);
    repeat (62) @(posedge clk);
    #1 hit_valid = '0;
    @(negedge clk);
    chk("R8 counter saturates", 32'(drop_count), 255);

    wait_time(1301);
    chk("R7 fourth window header ts", 32'(out_ts), 700);
    wait_time(1330);
    chk("R6 every expected word emitted", 32'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule